// File: doc/BRIEF.md
# Single-Error-Correcting RAM Guard with Check-Bit Injection

This block wraps a single-port word memory and protects every 32-bit word with seven check bits: six Hamming bits and one overall parity bit. A normal write always stores freshly computed check bits beside the data. A normal read decodes the stored word. A single flipped bit is repaired in the returned data, and a two-bit corruption is reported as uncorrectable.

A small register interface sits next to the memory port. The control register holds a 4-bit detection key and a check-bit write enable. Detection is off only when the key is 0x5. Turning detection off never stops the block from computing and storing check bits. To plant an error, software sets the check-bit write enable and writes the check-bit array directly, which leaves the data word untouched. A test can then recreate single-bit or double-bit mismatches in a controlled way.

A sticky status register keeps separate flags for corrected and uncorrectable errors, and each flag is cleared by writing 1 to it. A third register holds the address of the first error seen since the flags were last clear.

Top module: `ecc_ram_guard`

## Requirements
- R1: A read with `mem_chk_sel`=0 returns the last word written to that address on `mem_rdata`, with `mem_rvalid`=1, one clock after the request is registered. `rd_sec` and `rd_ded` stay 0 when the stored word is intact.
- R2: If the stored data differs in exactly one bit from the word its check bits were computed for, the read returns the corrected word with `rd_sec`=1 and `rd_ded`=0.
- R3: If exactly one of the seven stored check bits is flipped, the read returns the stored data unchanged with `rd_sec`=1 and `rd_ded`=0.
- R4: A two-bit mismatch gives `rd_ded`=1 and `rd_sec`=0, and the stored data is returned as it is. The two flags are never both 1.
- R5: When the key is 0x5, reads return the raw stored data, `rd_sec`=`rd_ded`=0, and no status flag is set. Every other key value (0x0 to 0xF except 0x5) keeps correction active.
- R6: Check bits are computed and stored on every normal write, whatever the key. A word written with detection off reads back clean once detection is on again.
- R7: With the check-bit write enable set, a write with `mem_chk_sel`=1 stores `mem_wdata[6:0]` into the check-bit array and leaves the data array unchanged. A read with `mem_chk_sel`=1 returns the stored check bits in `mem_rdata[6:0]`, with the upper bits 0 and both error outputs 0.
- R8: With the check-bit write enable clear, a write with `mem_chk_sel`=1 has no effect on either array.
- R9: Status register (`reg_addr`=1): bit 0 is the corrected-error flag and bit 1 is the uncorrectable flag. Both are sticky and are set one clock after the flagged read data appears. Writing 1 to a bit clears it, and writing 0 leaves it as it is. If a clear and a new error of the same kind fall in the same cycle, the flag stays set.
- R10: Error address register (`reg_addr`=2, low `AW` bits) captures the address of an error only when both flags are clear at that moment. It holds that address until both flags have been cleared.
- R11: After reset the control register reads 0x0000000A (key 0xA, enable 0), status reads 0, and `mem_rvalid` is 0.
- R12: Control register (`reg_addr`=0): key in bits 3:0, check-bit write enable in bit 8, all other bits read 0. Register reads on `reg_rdata` are combinational, and writes take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_req | input | 1 | Memory access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_chk_sel | input | 1 | 1 = access targets the check-bit array |
| mem_addr | input | AW | Word address |
| mem_wdata | input | 32 | Write data (bits 6:0 used for a check-bit write) |
| mem_rdata | output | 32 | Read data, corrected when detection is on |
| mem_rvalid | output | 1 | Read data valid |
| rd_sec | output | 1 | Corrected single-bit error on this read |
| rd_ded | output | 1 | Uncorrectable double-bit error on this read |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 error address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
A read is launched at a falling edge and captured at the next rising edge. `mem_rdata`, `mem_rvalid`, `rd_sec` and `rd_ded` are sampled at the falling edge that follows. The sticky status and the error address change one rising edge later, so the bench reads those registers only after one further falling edge. For the same-cycle clear case, the clear is driven at the falling edge where the read result is sampled, which puts it on the same rising edge as the flag update. Errors are planted by reading the check bits, rewriting the data with chosen bits flipped, and restoring the old check bits directly. Every data bit position and every check bit position is swept this way.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    localparam int DW  = 32;
    localparam int HW  = 6;
    localparam int CW  = HW + 1;
    localparam int MAXPOS = DW + HW;

    // Codeword position of data bit idx: non-power-of-two slots 3,5,6,7,9...
    function automatic logic [HW-1:0] data_pos(input int idx);
        logic [HW-1:0] r;
        int cnt;
        r   = '0;
        cnt = 0;
        for (int p = 1; p <= MAXPOS; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == idx) r = p[HW-1:0];
                cnt++;
            end
        end
        return r;
    endfunction

    function automatic logic [HW-1:0] ham_bits(input logic [DW-1:0] d);
        logic [HW-1:0] h;
        logic [HW-1:0] p;
        h = '0;
        for (int i = 0; i < DW; i++) begin
            p = data_pos(i);
            for (int k = 0; k < HW; k++) begin
                if (p[k]) h[k] = h[k] ^ d[i];
            end
        end
        return h;
    endfunction

    function automatic logic [CW-1:0] encode(input logic [DW-1:0] d);
        logic [HW-1:0] h;
        h = ham_bits(d);
        return {^{d, h}, h};
    endfunction
endpackage

// File: rtl/ecc_store.sv
module ecc_store #(
    parameter int AW = 4,
    parameter int DW = 32,
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          wr_data_en,
    input  logic          wr_chk_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [CW-1:0] wchk,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] rchk
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] data_mem [DEPTH];
    logic [CW-1:0] chk_mem  [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_data_en) data_mem[addr] <= wdata;
        if (wr_chk_en)  chk_mem[addr]  <= wchk;
        if (rd_en) begin
            rdata <= data_mem[addr];
            rchk  <= chk_mem[addr];
        end
    end
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
    import ecc_pkg::*;
(
    input  logic          enable,
    input  logic [DW-1:0] raw_d,
    input  logic [CW-1:0] raw_c,
    output logic [DW-1:0] data_o,
    output logic          sec_o,
    output logic          ded_o
);
    logic [HW-1:0] syn;
    logic          ovp;
    logic          syn_pow2;
    logic [DW-1:0] fix_mask;
    logic          hit;

    always_comb begin
        syn      = ham_bits(raw_d) ^ raw_c[HW-1:0];
        ovp      = ^{raw_d, raw_c};
        syn_pow2 = ((syn & (syn - 1'b1)) == '0);
        fix_mask = '0;
        for (int i = 0; i < DW; i++) begin
            fix_mask[i] = (syn != '0) && (data_pos(i) == syn);
        end
        hit = |fix_mask;

        data_o = raw_d;
        sec_o  = 1'b0;
        ded_o  = 1'b0;
        if (enable) begin
            if (ovp && (syn_pow2 || hit)) begin
                sec_o  = 1'b1;
                data_o = raw_d ^ fix_mask;
            end else if (syn != '0) begin
                ded_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ecc_ram_guard.sv
module ecc_ram_guard
    import ecc_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mem_req,
    input  logic          mem_we,
    input  logic          mem_chk_sel,
    input  logic [AW-1:0] mem_addr,
    input  logic [31:0]   mem_wdata,
    output logic [31:0]   mem_rdata,
    output logic          mem_rvalid,
    output logic          rd_sec,
    output logic          rd_ded,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata
);
    localparam logic [3:0] KEY_OFF   = 4'h5;
    localparam logic [3:0] KEY_RESET = 4'hA;
    localparam int         CBEN_BIT  = 8;

    typedef struct packed {
        logic [3:0]    key;
        logic          cben;
        logic          sec_f;
        logic          ded_f;
        logic [AW-1:0] eaddr;
        logic          rvalid;
        logic [AW-1:0] raddr;
        logic          rchk;
    } state_t;

    state_t st_q, st_d;

    logic          wr_norm, wr_dir, rd_en;
    logic [CW-1:0] wchk_mux;
    logic [DW-1:0] raw_d, dec_d;
    logic [CW-1:0] raw_c;
    logic          dec_sec, dec_ded, det_on;
    logic          clr_sec, clr_ded;

    assign wr_norm  = mem_req && mem_we && !mem_chk_sel;
    assign wr_dir   = mem_req && mem_we && mem_chk_sel && st_q.cben;
    assign rd_en    = mem_req && !mem_we;
    assign wchk_mux = wr_dir ? mem_wdata[CW-1:0] : encode(mem_wdata);
    assign det_on   = (st_q.key != KEY_OFF) && !st_q.rchk;

    ecc_store #(.AW(AW), .DW(DW), .CW(CW)) u_store (
        .clk        (clk),
        .wr_data_en (wr_norm),
        .wr_chk_en  (wr_norm || wr_dir),
        .rd_en      (rd_en),
        .addr       (mem_addr),
        .wdata      (mem_wdata),
        .wchk       (wchk_mux),
        .rdata      (raw_d),
        .rchk       (raw_c)
    );

    ecc_dec u_dec (
        .enable (det_on),
        .raw_d  (raw_d),
        .raw_c  (raw_c),
        .data_o (dec_d),
        .sec_o  (dec_sec),
        .ded_o  (dec_ded)
    );

    always_comb begin
        mem_rvalid = st_q.rvalid;
        mem_rdata  = st_q.rchk ? {{(32-CW){1'b0}}, raw_c} : dec_d;
        rd_sec     = st_q.rvalid && dec_sec;
        rd_ded     = st_q.rvalid && dec_ded;
        case (reg_addr)
            2'd0:    reg_rdata = {23'b0, st_q.cben, 4'b0, st_q.key};
            2'd1:    reg_rdata = {30'b0, st_q.ded_f, st_q.sec_f};
            2'd2:    reg_rdata = {{(32-AW){1'b0}}, st_q.eaddr};
            default: reg_rdata = '0;
        endcase
    end

    assign clr_sec = reg_we && (reg_addr == 2'd1) && reg_wdata[0];
    assign clr_ded = reg_we && (reg_addr == 2'd1) && reg_wdata[1];

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd_en;
        if (rd_en) begin
            st_d.raddr = mem_addr;
            st_d.rchk  = mem_chk_sel;
        end
        if (reg_we && reg_addr == 2'd0) begin
            st_d.key  = reg_wdata[3:0];
            st_d.cben = reg_wdata[CBEN_BIT];
        end
        if (clr_sec) st_d.sec_f = 1'b0;
        if (clr_ded) st_d.ded_f = 1'b0;
        if (rd_sec || rd_ded) begin
            if (!(st_q.sec_f || st_q.ded_f)) st_d.eaddr = st_q.raddr;
            if (rd_sec) st_d.sec_f = 1'b1;
            if (rd_ded) st_d.ded_f = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.key    <= KEY_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    // R1: a read request is answered on the next cycle
    a_r1_read_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> mem_rvalid);

    // R4: corrected and uncorrectable never reported together
    a_r4_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> !(rd_sec && rd_ded));

    // R5: detection key off keeps error outputs quiet
    a_r5_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rvalid && st_q.key == KEY_OFF) |-> (!rd_sec && !rd_ded));

    // R9: corrected flag stays set unless a clear is written
    a_r9_sec_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sec_f && !clr_sec) |=> st_q.sec_f);

    // R10: captured address holds while any flag is set
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sec_f || st_q.ded_f) |=> $stable(st_q.eaddr));
endmodule

// File: tb/sim_ecc_ram_guard.sv
module sim_ecc_ram_guard;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_req = 1'b0, mem_we = 1'b0, mem_chk_sel = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [31:0]   mem_wdata = '0;
    logic [31:0]   mem_rdata;
    logic          mem_rvalid, rd_sec, rd_ded;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] r_data;
    logic        r_valid, r_sec, r_ded;
    logic [31:0] r_reg;

    ecc_ram_guard #(.AW(AW)) u0 (.*);

    always #2 clk = ~clk;

    function automatic logic [31:0] pat(input int i);
        return 32'hA5C3_0F17 ^ (i * 32'h9E37_79B9);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic mwrite(input logic [AW-1:0] a, input logic [31:0] d, input logic cs);
        @(negedge clk);
        mem_req = 1; mem_we = 1; mem_chk_sel = cs; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_req = 0; mem_we = 0; mem_chk_sel = 0;
    endtask

    task automatic mread(input logic [AW-1:0] a, input logic cs);
        @(negedge clk);
        mem_req = 1; mem_we = 0; mem_chk_sel = cs; mem_addr = a;
        @(negedge clk);
        mem_req = 0; mem_chk_sel = 0;
        r_data = mem_rdata; r_valid = mem_rvalid; r_sec = rd_sec; r_ded = rd_ded;
    endtask

    task automatic rwrite(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rread(input logic [1:0] a);
        @(negedge clk);
        reg_addr = a;
        #1 r_reg = reg_rdata;
    endtask

    // plant data error: data becomes d^flip while check bits stay those of d
    task automatic plant_data(input logic [AW-1:0] a, input logic [31:0] d, input logic [31:0] flip);
        logic [31:0] c;
        mwrite(a, d, 0);
        mread(a, 1);
        c = r_data;
        mwrite(a, d ^ flip, 0);
        mwrite(a, c, 1);
    endtask

    task automatic read_expect(input string tag, input logic [AW-1:0] a,
                               input logic [31:0] ed, input logic es, input logic edd);
        mread(a, 0);
        chk({tag, " data"}, r_data, ed);
        chk({tag, " valid"}, {31'b0, r_valid}, 32'd1);
        chk({tag, " sec"}, {31'b0, r_sec}, {31'b0, es});
        chk({tag, " ded"}, {31'b0, r_ded}, {31'b0, edd});
    endtask

    initial begin
        logic [31:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R11 / R12 reset state
        rread(2'd0); chk("R11 ctrl reset", r_reg, 32'h0000_000A);
        rread(2'd1); chk("R11 status reset", r_reg, 32'h0);
        chk("R11 rvalid reset", {31'b0, mem_rvalid}, 32'h0);

        // R1 clean round trip on every address
        for (int a = 0; a < 16; a++) mwrite(a[AW-1:0], pat(a), 0);
        for (int a = 0; a < 16; a++) read_expect("R1", a[AW-1:0], pat(a), 0, 0);

        // R12 control layout
        rwrite(2'd0, 32'hFFFF_FE0A);
        rread(2'd0); chk("R12 ctrl layout", r_reg, 32'h0000_000A);
        rwrite(2'd0, 32'h0000_010A);
        rread(2'd0); chk("R12 ctrl enable", r_reg, 32'h0000_010A);

        // R2 every data bit position
        for (int b = 0; b < 32; b++) begin
            plant_data(b % 16, pat(b + 40), 32'h1 << b);
            read_expect("R2", b % 16, pat(b + 40), 1, 0);
        end

        // R3 / R7 every check bit position
        for (int k = 0; k < 7; k++) begin
            mwrite(5, pat(k + 80), 0);
            mread(5, 1);
            c = r_data;
            chk("R7 chk upper zero", c & 32'hFFFF_FF80, 32'h0);
            chk("R7 chk read flags", {30'b0, r_sec, r_ded}, 32'h0);
            mwrite(5, c ^ (32'h1 << k), 1);
            mread(5, 1);
            chk("R7 direct chk stored", r_data, c ^ (32'h1 << k));
            read_expect("R3", 5, pat(k + 80), 1, 0);
        end

        // R4 double errors: data pairs and check pairs
        for (int b = 0; b < 31; b += 3) begin
            plant_data(6, pat(b + 100), 32'h3 << b);
            read_expect("R4 data pair", 6, pat(b + 100) ^ (32'h3 << b), 0, 1);
        end
        for (int k = 0; k < 6; k++) begin
            mwrite(8, pat(k + 120), 0);
            mread(8, 1);
            c = r_data;
            mwrite(8, c ^ (32'h3 << k), 1);
            read_expect("R4 chk pair", 8, pat(k + 120), 0, 1);
        end
        rread(2'd1); chk("R9 both flags", r_reg, 32'h3);

        // R9 / R10 sticky flags and first-error address
        rwrite(2'd1, 32'h3);
        rread(2'd1); chk("R9 w1c clear", r_reg, 32'h0);
        mwrite(3, pat(200), 0); mread(3, 1); mwrite(3, r_data ^ 32'h1, 1);
        mwrite(7, pat(201), 0); mread(7, 1); mwrite(7, r_data ^ 32'h2, 1);
        read_expect("R10 first", 3, pat(200), 1, 0);
        rread(2'd1); chk("R9 sec set", r_reg, 32'h1);
        rread(2'd2); chk("R10 addr first", r_reg, 32'd3);
        read_expect("R10 second", 7, pat(201), 1, 0);
        rread(2'd2); chk("R10 addr held", r_reg, 32'd3);
        rwrite(2'd1, 32'h0);
        rread(2'd1); chk("R9 write zero no effect", r_reg, 32'h1);
        rwrite(2'd1, 32'h1);
        rread(2'd1); chk("R9 cleared", r_reg, 32'h0);
        read_expect("R10 recapture", 7, pat(201), 1, 0);
        rread(2'd2); chk("R10 addr new", r_reg, 32'd7);
        // clear and new error in the same edge: flag stays set
        @(negedge clk);
        mem_req = 1; mem_we = 0; mem_addr = 3;
        @(negedge clk);
        mem_req = 0;
        chk("R9 same-cycle read sec", {31'b0, rd_sec}, 32'h1);
        reg_we = 1; reg_addr = 2'd1; reg_wdata = 32'h1;
        @(negedge clk);
        reg_we = 0;
        rread(2'd1); chk("R9 set wins", r_reg, 32'h1);

        // R5 detection off by key 0x5 only
        plant_data(11, pat(300), 32'h10);
        rwrite(2'd1, 32'h3);
        rwrite(2'd0, 32'h0000_0105);
        read_expect("R5 off raw", 11, pat(300) ^ 32'h10, 0, 0);
        rread(2'd1); chk("R5 no status", r_reg, 32'h0);
        for (int key = 0; key < 16; key++) begin
            if (key != 5) begin
                rwrite(2'd0, 32'h100 | key);
                read_expect("R5 other key active", 11, pat(300), 1, 0);
            end
        end

        // R6 check bits generated while detection is off
        rwrite(2'd0, 32'h0000_0105);
        mwrite(12, pat(400), 0);
        rwrite(2'd0, 32'h0000_000A);
        read_expect("R6 clean after off", 12, pat(400), 0, 0);

        // R8 direct write blocked when enable clear
        mread(12, 1);
        c = r_data;
        mwrite(12, c ^ 32'h3, 1);
        mread(12, 1);
        chk("R8 chk unchanged", r_data, c);
        read_expect("R8 data clean", 12, pat(400), 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end
endmodule